// File: doc/BRIEF.md
# SPI FIFO Threshold Interrupt Unit

This block holds the data queues of an SPI master controller. Outbound words wait in a transmit FIFO until the serial shift engine takes them. Inbound words from the engine wait in a receive FIFO until software reads them. A small register port gives software four kinds of access: it pushes and pops data, sets a level threshold per direction, reads the live fill levels, and reads a raw interrupt status word. A write to a dedicated address clears the sticky overrun flag.

The status word has three conditions. Transmit-empty says the outbound queue has drained to its threshold or below. Receive-full says the inbound queue has reached its threshold plus one. Receive-overrun says a word arrived while the inbound queue had no room; that word was thrown away and the queued data was kept. A mask register selects which of these conditions drive the single interrupt output. Each threshold register is one bit narrower than the level it is compared with. A threshold write that is out of range is ignored, so software can find the queue depth by writing rising values and reading them back.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: After reset, both FIFOs are empty, both thresholds and the mask read 0, the overrun flag is clear, the status word reads 0x01 and irq is low.
- R2: Threshold registers hold ABW = log2(DEPTH) bits. Level registers (address 2 transmit, address 3 receive) hold ABW+1 bits and read DEPTH when the FIFO is full. A transmit push into a full FIFO leaves the level at DEPTH.
- R3: A write to the transmit threshold (address 0) with a value greater than or equal to DEPTH is ignored, and the old value is kept.
- R4: A write to the receive threshold (address 1) is ignored when the value plus one exceeds DEPTH.
- R5: Status bit 0 (transmit-empty) is 1 exactly when the transmit level is less than or equal to the transmit threshold.
- R6: Status bit 4 (receive-full) is 1 exactly when the receive level is at least the receive threshold plus one.
- R7: A receive push while the receive FIFO is full and no pop occurs is discarded. It sets status bit 3 (receive-overrun), the level stays at DEPTH, and the queued words come out unchanged. A full-depth receive with an empty transmit side reads 0x11; one more word makes it 0x19.
- R8: The overrun bit stays set until any write to address 5, which clears it.
- R9: Software writes 1, 2, 3 and so on to a threshold and reads each value back. The first value that fails to read back equals DEPTH.
- R10: irq is the OR of the status bits ANDed with the mask register (address 6), which uses the same bit positions as the status word.
- R11: A write to address 7 pushes onto the transmit FIFO. tx_data shows the oldest word and tx_pop removes it. A read of address 7 with reg_rd_en shows and pops the oldest received word. Both FIFOs keep arrival order.
- R12: Status bits 1, 2, 5, 6 and 7 always read 0. The status word is at address 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Read strobe; pops the receive FIFO at address 7 |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Combinational read data for reg_addr |
| tx_pop | input | 1 | Shift engine takes the oldest transmit word |
| tx_data | output | WIDTH | Oldest transmit word |
| tx_avail | output | 1 | Transmit FIFO not empty |
| rx_push | input | 1 | Shift engine delivers a received word |
| rx_data | input | WIDTH | Received word |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench builds the unit with DEPTH = 4, WIDTH = 8 and REG_W = 8. A four-entry queue fills in a few cycles, so full, overrun and drop conditions come up quickly. It also makes every threshold value from 0 to 3, and the out-of-range edge at 4, cheap to sweep. The same small depth makes the depth-discovery loop end at a known value. It also lets the table cover threshold and level pairs on both sides of each comparison.

// File: rtl/spi_fifo_pkg.sv
// Shared register map and status bit positions for the SPI FIFO unit.
// Assumes a 3-bit register address space.
package spi_fifo_pkg;
    typedef enum logic [2:0] {
        ADR_TX_THR  = 3'd0,
        ADR_RX_THR  = 3'd1,
        ADR_TX_LVL  = 3'd2,
        ADR_RX_LVL  = 3'd3,
        ADR_RAW     = 3'd4,
        ADR_OVR_CLR = 3'd5,
        ADR_MASK    = 3'd6,
        ADR_DATA    = 3'd7
    } reg_addr_e;

    localparam int ST_W   = 5;
    localparam int ST_TXE = 0;
    localparam int ST_RXO = 3;
    localparam int ST_RXF = 4;
endpackage

// File: rtl/spi_sync_fifo.sv
// Single-clock FIFO with a fill-level counter.
// A push into a full FIFO is dropped unless a pop happens in the same cycle.
// A pop from an empty FIFO is ignored. Assumes DEPTH is a power of two.
module spi_sync_fifo #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [WIDTH-1:0]           push_data,
    input  logic                       pop,
    output logic [WIDTH-1:0]           head,
    output logic [$clog2(DEPTH):0]     level,
    output logic                       full,
    output logic                       empty,
    output logic                       dropped
);
    localparam int ABW = $clog2(DEPTH);
    localparam logic [ABW:0] DEPTH_L = (ABW+1)'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [ABW-1:0]   wptr, rptr;
    logic             pop_ok, push_ok;

    // Accept conditions for each side
    always_comb begin
        pop_ok  = pop && !empty;
        push_ok = push && (!full || pop_ok);
        dropped = push && !push_ok;
    end

    assign full  = (level == DEPTH_L);
    assign empty = (level == '0);
    assign head  = mem[rptr];

    // Storage write
    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= push_data;
    end

    // Pointer and level bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (push_ok) wptr <= wptr + 1'b1;
            if (pop_ok)  rptr <= rptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // R2
    level_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= DEPTH_L);

    // R7
    drop_keeps_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dropped |=> (level == DEPTH_L));
endmodule

// File: rtl/spi_thresh_reg.sv
// Threshold register of ABW bits. Writes out of range are ignored.
// RX_STYLE selects the receive rule (value+1 must not exceed DEPTH);
// otherwise the transmit rule (value must be below DEPTH) applies.
module spi_thresh_reg #(
    parameter int DEPTH    = 32,
    parameter int REG_W    = 8,
    parameter bit RX_STYLE = 1'b0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [REG_W-1:0]          wdata,
    output logic [$clog2(DEPTH)-1:0]  q
);
    localparam int ABW = $clog2(DEPTH);
    localparam logic [REG_W:0] DEPTH_W = (REG_W+1)'(DEPTH);

    logic [REG_W:0] wide;
    logic           accept;

    assign wide = {1'b0, wdata};

    generate
        if (RX_STYLE) begin : g_rx_rule
            // Range test on the incremented value
            assign accept = (wide + (REG_W+1)'(1)) <= DEPTH_W;
        end else begin : g_tx_rule
            // Range test on the raw value
            assign accept = wide < DEPTH_W;
        end
    endgenerate

    // Register update
    always_ff @(posedge clk) begin
        if (!rst_n)                q <= '0;
        else if (wr_en && accept)  q <= wdata[ABW-1:0];
    end

    // R3 R4
    ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wide >= DEPTH_W)) |=> $stable(q));
endmodule

// File: rtl/spi_fifo_irq_unit.sv
// Transmit/receive FIFOs, thresholds, raw status and masked interrupt
// for an SPI master. Register reads are combinational. A read of the data
// address with reg_rd_en pops the receive FIFO. Assumes WIDTH <= REG_W and
// ABW+1 <= REG_W.
module spi_fifo_irq_unit
    import spi_fifo_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int WIDTH = 8,
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       reg_addr,
    input  logic             reg_wr_en,
    input  logic             reg_rd_en,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             tx_pop,
    output logic [WIDTH-1:0] tx_data,
    output logic             tx_avail,
    input  logic             rx_push,
    input  logic [WIDTH-1:0] rx_data,
    output logic             irq
);
    localparam int ABW = $clog2(DEPTH);

    reg_addr_e        addr;
    logic [ABW-1:0]   tx_thr, rx_thr;
    logic [ABW:0]     tx_lvl, rx_lvl;
    logic [WIDTH-1:0] rx_head;
    logic             tx_full, tx_empty, tx_drop;
    logic             rx_full, rx_empty, rx_drop;
    logic             ovr, ovr_clr;
    logic [ST_W-1:0]  mask, raw;
    logic             wr_tx_thr, wr_rx_thr, wr_data, rd_data, wr_mask;

    assign addr = reg_addr_e'(reg_addr);

    // Decode write and read strobes
    always_comb begin
        wr_tx_thr = reg_wr_en && (addr == ADR_TX_THR);
        wr_rx_thr = reg_wr_en && (addr == ADR_RX_THR);
        wr_data   = reg_wr_en && (addr == ADR_DATA);
        wr_mask   = reg_wr_en && (addr == ADR_MASK);
        ovr_clr   = reg_wr_en && (addr == ADR_OVR_CLR);
        rd_data   = reg_rd_en && (addr == ADR_DATA);
    end

    spi_sync_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(wr_data), .push_data(reg_wdata[WIDTH-1:0]),
        .pop(tx_pop), .head(tx_data), .level(tx_lvl),
        .full(tx_full), .empty(tx_empty), .dropped(tx_drop)
    );

    spi_sync_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .push_data(rx_data),
        .pop(rd_data), .head(rx_head), .level(rx_lvl),
        .full(rx_full), .empty(rx_empty), .dropped(rx_drop)
    );

    spi_thresh_reg #(.DEPTH(DEPTH), .REG_W(REG_W), .RX_STYLE(1'b0)) u_tx_thr (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_tx_thr), .wdata(reg_wdata), .q(tx_thr)
    );

    spi_thresh_reg #(.DEPTH(DEPTH), .REG_W(REG_W), .RX_STYLE(1'b1)) u_rx_thr (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_rx_thr), .wdata(reg_wdata), .q(rx_thr)
    );

    assign tx_avail = !tx_empty;

    // Sticky overrun flag: a new drop wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)       ovr <= 1'b0;
        else if (rx_drop) ovr <= 1'b1;
        else if (ovr_clr) ovr <= 1'b0;
    end

    // Interrupt mask register
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (wr_mask) mask <= reg_wdata[ST_W-1:0];
    end

    // Raw status word assembly
    always_comb begin
        raw         = '0;
        raw[ST_TXE] = ({1'b0, tx_thr} >= tx_lvl);
        raw[ST_RXO] = ovr;
        raw[ST_RXF] = (rx_lvl >= ({1'b0, rx_thr} + 1'b1));
    end

    assign irq = |(raw & mask);

    // Register read multiplexer
    always_comb begin
        unique case (addr)
            ADR_TX_THR:  reg_rdata = REG_W'(tx_thr);
            ADR_RX_THR:  reg_rdata = REG_W'(rx_thr);
            ADR_TX_LVL:  reg_rdata = REG_W'(tx_lvl);
            ADR_RX_LVL:  reg_rdata = REG_W'(rx_lvl);
            ADR_RAW:     reg_rdata = REG_W'(raw);
            ADR_MASK:    reg_rdata = REG_W'(mask);
            ADR_DATA:    reg_rdata = REG_W'(rx_head);
            default:     reg_rdata = '0;
        endcase
    end

    // R7
    drop_sets_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full && !rd_data) |=> ovr);

    // R8
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !ovr_clr) |=> ovr);

    // R8
    overrun_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_clr && !rx_push) |=> !ovr);

    // R2
    tx_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && !tx_pop) |=> tx_full);
endmodule

// File: tb/sim_spi_fifo_irq_unit.sv
`timescale 1ns/1ps
module sim_spi_fifo_irq_unit;
    localparam int DEPTH = 4;
    localparam int WIDTH = 8;
    localparam int REG_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       reg_addr = '0;
    logic             reg_wr_en = 1'b0;
    logic             reg_rd_en = 1'b0;
    logic [REG_W-1:0] reg_wdata = '0;
    logic [REG_W-1:0] reg_rdata;
    logic             tx_pop = 1'b0;
    logic [WIDTH-1:0] tx_data;
    logic             tx_avail;
    logic             rx_push = 1'b0;
    logic [WIDTH-1:0] rx_data = '0;
    logic             irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    spi_fifo_irq_unit #(.DEPTH(DEPTH), .WIDTH(WIDTH), .REG_W(REG_W)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_rd_en(reg_rd_en), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_pop(tx_pop), .tx_data(tx_data), .tx_avail(tx_avail),
        .rx_push(rx_push), .rx_data(rx_data), .irq(irq)
    );

    // {tx_thr, rx_thr, tx_count, rx_count, expected status}
    localparam logic [39:0] VEC [0:7] = '{
        {8'd0, 8'd0, 8'd0, 8'd0, 8'h01},
        {8'd0, 8'd0, 8'd1, 8'd1, 8'h10},
        {8'd2, 8'd1, 8'd2, 8'd1, 8'h01},
        {8'd2, 8'd1, 8'd3, 8'd2, 8'h10},
        {8'd3, 8'd3, 8'd4, 8'd4, 8'h10},
        {8'd3, 8'd3, 8'd3, 8'd3, 8'h01},
        {8'd3, 8'd2, 8'd2, 8'd3, 8'h11},
        {8'd1, 8'd2, 8'd2, 8'd2, 8'h00}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_addr = 3'(a); reg_wdata = REG_W'(d); reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        reg_addr = 3'(a);
        #1 d = int'(reg_rdata);
    endtask

    task automatic rx_pop_rd(output int d);
        @(negedge clk);
        reg_addr = 3'd7; reg_rd_en = 1'b1;
        #1 d = int'(reg_rdata);
        @(negedge clk);
        reg_rd_en = 1'b0;
    endtask

    task automatic rx_in(input int d);
        @(negedge clk);
        rx_data = WIDTH'(d); rx_push = 1'b1;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic tx_take(output int d);
        @(negedge clk);
        #1 d = int'(tx_data);
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    // Watchdog: an expired run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(0, v); chk("R1 tx_thr", v, 0);
        rd(1, v); chk("R1 rx_thr", v, 0);
        rd(2, v); chk("R1 tx_lvl", v, 0);
        rd(3, v); chk("R1 rx_lvl", v, 0);
        rd(6, v); chk("R1 mask", v, 0);
        rd(4, v); chk("R1 status", v, 'h01);
        chk("R1 irq", int'(irq), 0);

        // Table walk: R5 R6 R12
        for (int i = 0; i < 8; i++) begin
            wr(0, int'(VEC[i][39:32]));
            wr(1, int'(VEC[i][31:24]));
            for (int k = 0; k < int'(VEC[i][23:16]); k++) wr(7, 8'h40 + k);
            for (int k = 0; k < int'(VEC[i][15:8]); k++) rx_in(8'h80 + k);
            rd(4, v);
            chk($sformatf("R5 R6 R12 vector %0d", i), v, int'(VEC[i][7:0]));
            for (int k = 0; k < int'(VEC[i][23:16]); k++) tx_take(v);
            for (int k = 0; k < int'(VEC[i][15:8]); k++) rx_pop_rd(v);
        end

        // R11 order on both FIFOs
        wr(0, 0); wr(1, 0);
        wr(7, 'hA1); wr(7, 'hB2); wr(7, 'hC3);
        chk("R11 tx_avail", int'(tx_avail), 1);
        tx_take(v); chk("R11 tx first", v, 'hA1);
        tx_take(v); chk("R11 tx second", v, 'hB2);
        tx_take(v); chk("R11 tx third", v, 'hC3);
        chk("R11 tx drained", int'(tx_avail), 0);
        rx_in('h11); rx_in('h22); rx_in('h33);
        rx_pop_rd(v); chk("R11 rx first", v, 'h11);
        rx_pop_rd(v); chk("R11 rx second", v, 'h22);
        rx_pop_rd(v); chk("R11 rx third", v, 'h33);

        // R2 tx level full and extra push
        for (int k = 0; k < 5; k++) wr(7, k);
        rd(2, v); chk("R2 tx level at depth", v, DEPTH);
        for (int k = 0; k < 4; k++) tx_take(v);
        rd(2, v); chk("R2 tx level drained", v, 0);

        // R7 full-depth receive then overrun
        for (int k = 0; k < 4; k++) rx_in('h50 + k);
        rd(4, v); chk("R7 full transfer status", v, 'h11);
        rd(3, v); chk("R2 rx level at depth", v, DEPTH);
        rx_in('hEE);
        rd(4, v); chk("R7 overrun status", v, 'h19);
        rd(3, v); chk("R7 level held", v, DEPTH);

        // R10 masking
        wr(6, 'h08); #1 chk("R10 irq from overrun", int'(irq), 1);
        wr(6, 'h02); #1 chk("R10 irq masked", int'(irq), 0);

        // R8 sticky until clear
        rx_pop_rd(v); chk("R7 kept oldest word", v, 'h50);
        rd(4, v); chk("R8 overrun sticky", v & 'h08, 'h08);
        for (int k = 1; k < 4; k++) begin
            rx_pop_rd(v); chk("R7 kept words", v, 'h50 + k);
        end
        wr(5, 0);
        rd(4, v); chk("R8 cleared", v, 'h01);

        // R3 R4 ignored writes
        wr(0, 2); wr(0, 4); rd(0, v); chk("R3 tx thr kept", v, 2);
        wr(0, 'hFF); rd(0, v); chk("R3 tx thr kept on large", v, 2);
        wr(1, 3); wr(1, 4); rd(1, v); chk("R4 rx thr kept", v, 3);

        // R9 depth discovery on both threshold registers
        for (int a = 0; a < 2; a++) begin
            int found = 0;
            wr(a, 0);
            for (int k = 1; k < 9 && found == 0; k++) begin
                wr(a, k); rd(a, v);
                if (v != k) found = k;
            end
            chk($sformatf("R9 depth via addr %0d", a), found, DEPTH);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule